// File: doc/BRIEF.md
# Tuner Synthesizer Configuration Slave

This block is a write-only two-wire serial slave that holds the programming state of a tuner frequency synthesizer. A fast system clock oversamples the bus clock and data lines and finds START and STOP conditions. The block compares each address byte against a fixed 7-bit pattern. Two bits of that pattern come from a strap input, so up to four synthesizers can share one bus. The block acknowledges by enabling an open-drain pull-down on the data line.

After a matching address, the block routes each data byte by its most significant bit and by the byte that came before it. A byte with MSB 0 opens a divider pair, and the byte after it completes the 15-bit division ratio. A byte with MSB 1 is the loop-control byte, and the byte after it is the band-port byte. Pairs may arrive in either order, and the master may end the transfer after any byte. The outputs are the latched division ratio, the loop-control flags and the five port bits.

Top module: `tuner_cfg_slave`

## Requirements
- R1: An address byte equal to {1,1,0,0,0,sel[1],sel[0],0}, where sel is the address-select input (decimal 192, 194, 196 and 198 for sel = 0, 1, 2 and 3), is acknowledged. Acknowledge means `sda_oe_o` is 1 while SCL is high in the ninth clock of the byte.
- R2: An address byte with any other value, including the right address with bit 0 (read/write) set to 1, is not acknowledged. Every byte after it up to the next START is then neither acknowledged nor able to change any output.
- R3: After an acknowledged address, every data byte is acknowledged. `sda_oe_o` changes only while the synchronized SCL is low.
- R4: A data byte with bit 7 = 0 opens a divider pair, and its bits 6..0 become ratio bits 14..8. The next byte supplies ratio bits 7..0. `div_ratio_o` takes the weighted sum (bit k weighs 2^k) when that second byte is received.
- R5: A data byte with bit 7 = 1 is a control byte. Bit 6 drives `cp_high_o`, bit 5 drives `div_test_o`, bit 4 drives `cp_off_o`, bits 2..1 drive `ref_sel_o[1:0]` and bit 0 drives `drive_off_o`. Bit 3 has no effect.
- R6: The byte right after a control byte is the port byte whatever its bit 7. `port_o` becomes {b6,b4,b2,b1,b0}, and bits 7, 5 and 3 have no effect.
- R7: The legal orders all program the block correctly. These are divider-pair then control-pair, control-pair then divider-pair, either pair alone, a divider pair then a lone control byte, a control pair then a lone divider high byte, and a lone control byte. A byte after a completed pair is routed again by its bit 7.
- R8: A divider high byte followed by STOP or START, with no low byte, leaves `div_ratio_o` unchanged. `div_ratio_o` changes only as a result of a received byte.
- R9: A repeated START (SDA falling while SCL is high) restarts address matching and clears the byte-pair tracking. STOP (SDA rising while SCL is high) also clears it.
- R10: After reset, all register outputs are 0 and `sda_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 2 | Address-select strap, bits 2..1 of the address byte |
| sda_oe_o | output | 1 | 1 = pull the data line low (acknowledge) |
| div_ratio_o | output | 15 | Programmable divider ratio |
| cp_high_o | output | 1 | Charge pump high-current select |
| div_test_o | output | 1 | Divider test mode enable |
| cp_off_o | output | 1 | Charge pump disable |
| ref_sel_o | output | 2 | Reference divider select |
| drive_off_o | output | 1 | Varicap drive disable |
| port_o | output | 5 | Band-switch port bits {P6,P4,P2,P1,P0} |

## Verification
In one cycle, the pair tracker can receive both a clear from a START or STOP and a decision about whether the next byte is a low half. If the clear loses, a fresh byte lands in a stale pair. The bench provokes this by sending a divider high byte and then a repeated START, or a STOP, before the low byte. It then checks that the ratio did not move and that the next MSB-0 byte is treated as a new high byte. The bench also ends a transfer right after a control byte and then opens a new one with a divider pair. The expected result is a ratio built only from the new pair, with the port bits untouched.

// File: rtl/tuner_cfg_pkg.sv
package tuner_cfg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RECV,
        PH_ACK,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_DIV_LO,
        PEND_PORT
    } pend_e;

    typedef struct packed {
        logic       cp_high;
        logic       div_test;
        logic       cp_off;
        logic [1:0] ref_sel;
        logic       drive_off;
    } loop_ctl_t;

    localparam logic [4:0] ADDR_FIXED = 5'b11000;
endpackage

// File: rtl/tcs_bus_sampler.sv
module tcs_bus_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [SYNC-1:0] scl_pipe;
        logic [SYNC-1:0] sda_pipe;
        logic            scl_prev;
        logic            sda_prev;
    } smp_t;

    smp_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.scl_pipe = {st_q.scl_pipe[SYNC-2:0], scl_i};
        st_d.sda_pipe = {st_q.sda_pipe[SYNC-2:0], sda_i};
        st_d.scl_prev = st_q.scl_pipe[SYNC-1];
        st_d.sda_prev = st_q.sda_pipe[SYNC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign scl_s    = st_q.scl_pipe[SYNC-1];
    assign sda_s    = st_q.sda_pipe[SYNC-1];
    assign scl_rise = scl_s & ~st_q.scl_prev;
    assign scl_fall = ~scl_s & st_q.scl_prev;
    assign start_o  = scl_s & st_q.scl_prev & st_q.sda_prev & ~sda_s;
    assign stop_o   = scl_s & st_q.scl_prev & ~st_q.sda_prev & sda_s;
endmodule

// File: rtl/tcs_byte_engine.sv
module tcs_byte_engine
    import tuner_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic [1:0] addr_sel_i,
    output logic       sda_oe_o,
    output logic       byte_stb_o,
    output logic [7:0] byte_o,
    output logic       skipping_o
);
    typedef struct packed {
        phase_e     phase;
        logic [3:0] cnt;
        logic [7:0] shreg;
        logic       is_addr;
        logic       oe;
        logic       stb;
        logic [7:0] data;
    } eng_t;

    eng_t st_d, st_q;
    logic [7:0] own_addr;

    assign own_addr = {ADDR_FIXED, addr_sel_i, 1'b0};

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (start_i) begin
            st_d.phase   = PH_RECV;
            st_d.cnt     = '0;
            st_d.is_addr = 1'b1;
            st_d.oe      = 1'b0;
        end else if (stop_i) begin
            st_d.phase = PH_IDLE;
            st_d.oe    = 1'b0;
        end else begin
            case (st_q.phase)
                PH_RECV: begin
                    if (scl_rise && st_q.cnt < 4'd8) begin
                        st_d.shreg = {st_q.shreg[6:0], sda_s};
                        st_d.cnt   = st_q.cnt + 4'd1;
                    end
                    if (scl_fall && st_q.cnt == 4'd8) begin
                        if (st_q.is_addr && st_q.shreg != own_addr) begin
                            st_d.phase = PH_SKIP;
                        end else begin
                            st_d.phase = PH_ACK;
                            st_d.oe    = 1'b1;
                            if (!st_q.is_addr) begin
                                st_d.stb  = 1'b1;
                                st_d.data = st_q.shreg;
                            end
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        st_d.oe      = 1'b0;
                        st_d.phase   = PH_RECV;
                        st_d.cnt     = '0;
                        st_d.is_addr = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign sda_oe_o   = st_q.oe;
    assign byte_stb_o = st_q.stb;
    assign byte_o     = st_q.data;
    assign skipping_o = (st_q.phase == PH_SKIP);
endmodule

// File: rtl/tcs_reg_router.sv
module tcs_reg_router
    import tuner_cfg_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             byte_stb_i,
    input  logic [7:0]       byte_i,
    output logic [DIV_W-1:0] div_o,
    output loop_ctl_t        ctl_o,
    output logic [4:0]       port_o
);
    localparam int HI_W = DIV_W - 8;

    typedef struct packed {
        pend_e            pend;
        logic [HI_W-1:0]  hi;
        logic [DIV_W-1:0] div;
        loop_ctl_t        ctl;
        logic [4:0]       port;
    } rtr_t;

    rtr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.pend = PEND_NONE;
        end else if (byte_stb_i) begin
            case (st_q.pend)
                PEND_DIV_LO: begin
                    st_d.div  = {st_q.hi, byte_i};
                    st_d.pend = PEND_NONE;
                end
                PEND_PORT: begin
                    st_d.port = {byte_i[6], byte_i[4], byte_i[2], byte_i[1], byte_i[0]};
                    st_d.pend = PEND_NONE;
                end
                default: begin
                    if (!byte_i[7]) begin
                        st_d.hi   = byte_i[HI_W-1:0];
                        st_d.pend = PEND_DIV_LO;
                    end else begin
                        st_d.ctl.cp_high   = byte_i[6];
                        st_d.ctl.div_test  = byte_i[5];
                        st_d.ctl.cp_off    = byte_i[4];
                        st_d.ctl.ref_sel   = byte_i[2:1];
                        st_d.ctl.drive_off = byte_i[0];
                        st_d.pend          = PEND_PORT;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: PEND_NONE, default: '0};
        else        st_q <= st_d;
    end

    assign div_o  = st_q.div;
    assign ctl_o  = st_q.ctl;
    assign port_o = st_q.port;
endmodule

// File: rtl/tuner_cfg_slave.sv
module tuner_cfg_slave
    import tuner_cfg_pkg::*;
#(
    parameter int SYNC  = 2,
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       addr_sel_i,
    output logic             sda_oe_o,
    output logic [DIV_W-1:0] div_ratio_o,
    output logic             cp_high_o,
    output logic             div_test_o,
    output logic             cp_off_o,
    output logic [1:0]       ref_sel_o,
    output logic             drive_off_o,
    output logic [4:0]       port_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic byte_stb, skipping;
    logic [7:0] byte_data;
    loop_ctl_t ctl;

    tcs_bus_sampler #(.SYNC(SYNC)) u_smp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_o(start_p), .stop_o(stop_p)
    );

    tcs_byte_engine u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_i(start_p), .stop_i(stop_p),
        .addr_sel_i(addr_sel_i), .sda_oe_o(sda_oe_o), .byte_stb_o(byte_stb),
        .byte_o(byte_data), .skipping_o(skipping)
    );

    tcs_reg_router #(.DIV_W(DIV_W)) u_rtr (
        .clk(clk), .rst_n(rst_n), .clear_i(start_p | stop_p),
        .byte_stb_i(byte_stb), .byte_i(byte_data),
        .div_o(div_ratio_o), .ctl_o(ctl), .port_o(port_o)
    );

    assign cp_high_o   = ctl.cp_high;
    assign div_test_o  = ctl.div_test;
    assign cp_off_o    = ctl.cp_off;
    assign ref_sel_o   = ctl.ref_sel;
    assign drive_off_o = ctl.drive_off;
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
    parameter int DIV_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             byte_stb,
    input logic             skipping,
    input logic [DIV_W-1:0] div,
    input logic [4:0]       port
);
    assert_oe_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_oe) |-> !scl_s);

    assert_strobe_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> sda_oe);

    assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        skipping |-> !sda_oe);

    assert_div_on_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(div) |-> $past(byte_stb));

    assert_port_on_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(port) |-> $past(byte_stb));
endmodule

bind tuner_cfg_slave tcs_checker #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
    .byte_stb(byte_stb), .skipping(skipping), .div(div_ratio_o), .port(port_o)
);

// File: tb/tb_tuner_cfg_slave.sv
module tb_tuner_cfg_slave;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] asel = 2'd0;
    logic sda_oe;
    logic [14:0] div_ratio;
    logic cp_high, div_test, cp_off, drive_off;
    logic [1:0] ref_sel;
    logic [4:0] port;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [14:0] exp_div;
    logic [5:0]  exp_ctl;
    logic [4:0]  exp_port;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    tuner_cfg_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel_i(asel), .sda_oe_o(sda_oe), .div_ratio_o(div_ratio),
        .cp_high_o(cp_high), .div_test_o(div_test), .cp_off_o(cp_off),
        .ref_sel_o(ref_sel), .drive_off_o(drive_off), .port_o(port)
    );

    function automatic logic [5:0] ctl_of(input logic [7:0] b);
        return {b[6], b[5], b[4], b[2], b[1], b[0]};
    endfunction

    function automatic logic [4:0] port_of(input logic [7:0] b);
        return {b[6], b[4], b[2], b[1], b[0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(1);
            scl_m = 1'b1; wq(2);
            scl_m = 1'b0; wq(1);
        end
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        ack = sda_oe;
        wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    // START, own address, then n data bytes, then STOP; returns acks seen on data bytes
    task automatic xfer(input int n, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3, output int acks);
        logic a;
        logic [7:0] bs [4];
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
        acks = 0;
        bus_start();
        send_byte({5'b11000, asel, 1'b0}, a);
        for (int i = 0; i < n; i++) begin
            send_byte(bs[i], a);
            if (a) acks++;
        end
        bus_stop();
    endtask

    task automatic check_all(input string tag);
        chk({tag, " div"}, {17'd0, div_ratio}, {17'd0, exp_div});
        chk({tag, " ctl"}, {26'd0, cp_high, div_test, cp_off, ref_sel, drive_off}, {26'd0, exp_ctl});
        chk({tag, " port"}, {27'd0, port}, {27'd0, exp_port});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int acks;
        logic a;
        logic [14:0] vals [8];
        logic [7:0] cb, pb;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10: reset state
        exp_div = '0; exp_ctl = '0; exp_port = '0;
        check_all("R10 reset");
        chk("R10 sda_oe", {31'd0, sda_oe}, 32'd0);

        // R1 / R2: address sweep across all strap settings
        for (int s = 0; s < 4; s++) begin
            asel = s[1:0];
            for (int v = 0; v < 4; v++) begin
                bus_start();
                send_byte({5'b11000, v[1:0], 1'b0}, a);
                bus_stop();
                chk($sformatf("R1 R2 addr sel=%0d byte=%0d", s, 192 + 2 * v),
                    {31'd0, a}, {31'd0, (s == v)});
            end
            bus_start();
            send_byte({5'b11000, s[1:0], 1'b1}, a);
            bus_stop();
            chk("R2 read bit set", {31'd0, a}, 32'd0);
        end
        asel = 2'd2;

        // R2: bytes after a foreign address are ignored
        bus_start();
        send_byte(8'hC0, a);
        send_byte(8'h12, a);
        chk("R2 ignored data no ack", {31'd0, a}, 32'd0);
        send_byte(8'h34, a);
        send_byte(8'hFF, a);
        send_byte(8'h5F, a);
        bus_stop();
        check_all("R2 ignored data");

        // R3 / R4: divider sweep
        vals[0] = 15'h7FFF; vals[1] = 15'h0001; vals[2] = 15'h4000; vals[3] = 15'h2AAA;
        vals[4] = 15'h5555; vals[5] = 15'h0100; vals[6] = 15'h00FF; vals[7] = 15'h0000;
        for (int i = 0; i < 23; i++) begin
            logic [14:0] v;
            v = (i < 8) ? vals[i] : 15'(1 << (i - 8));
            xfer(2, {1'b0, v[14:8]}, v[7:0], 8'h00, 8'h00, acks);
            exp_div = 15'(int'(v[14:8]) * 256 + int'(v[7:0]));
            chk("R3 divider acks", acks, 2);
            chk($sformatf("R4 divider %0d", v), {17'd0, div_ratio}, {17'd0, exp_div});
        end

        // R5: control byte sweep, ports untouched
        for (int k = 0; k < 128; k += 5) begin
            cb = 8'h80 | 8'(k);
            xfer(1, cb, 8'h00, 8'h00, 8'h00, acks);
            exp_ctl = ctl_of(cb);
            check_all($sformatf("R5 ctl %0h", cb));
        end
        cb = 8'hFF;
        xfer(1, cb, 8'h00, 8'h00, 8'h00, acks);
        exp_ctl = ctl_of(cb);
        check_all("R5 ctl ff");

        // R6: port byte by position, MSB of either value
        for (int p = 0; p < 32; p++) begin
            pb = {p[0], p[4], ~p[1], p[3], p[2] ^ p[0], p[2], p[1], p[0]};
            cb = 8'hC0 | 8'(p & 8'h17);
            xfer(2, cb, pb, 8'h00, 8'h00, acks);
            exp_ctl = ctl_of(cb);
            exp_port = port_of(pb);
            check_all($sformatf("R6 port %0d", p));
        end

        // R7: orders
        xfer(4, 8'h81, 8'h55, 8'h12, 8'h34, acks);
        exp_ctl = ctl_of(8'h81); exp_port = port_of(8'h55); exp_div = 15'h1234;
        chk("R7 four byte acks", acks, 4);
        check_all("R7 ctl-then-div");
        xfer(4, 8'h3C, 8'hA5, 8'hE2, 8'h8A, acks);
        exp_div = 15'h3CA5; exp_ctl = ctl_of(8'hE2); exp_port = port_of(8'h8A);
        check_all("R7 div-then-ctl");
        xfer(3, 8'h07, 8'h77, 8'h94, 8'h00, acks);
        exp_div = 15'h0777; exp_ctl = ctl_of(8'h94);
        check_all("R7 div-then-lone-ctl");
        xfer(3, 8'hA8, 8'h10, 8'h6E, 8'h00, acks);
        exp_ctl = ctl_of(8'hA8); exp_port = port_of(8'h10);
        check_all("R7 R8 ctl-then-lone-high");

        // R8: lone high byte then STOP
        xfer(1, 8'h11, 8'h00, 8'h00, 8'h00, acks);
        check_all("R8 lone high byte");
        // after a lone control byte, a new transfer starts with a divider pair
        xfer(1, 8'h82, 8'h00, 8'h00, 8'h00, acks);
        exp_ctl = ctl_of(8'h82);
        xfer(2, 8'h2B, 8'hCD, 8'h00, 8'h00, acks);
        exp_div = 15'h2BCD;
        check_all("R9 R7 pair cleared by stop");

        // R9: repeated START between high and low byte
        bus_start();
        send_byte({5'b11000, asel, 1'b0}, a);
        send_byte(8'h55, a);
        bus_start();
        check_all("R9 R8 repeated start keeps div");
        send_byte({5'b11000, asel, 1'b0}, a);
        chk("R9 readdress ack", {31'd0, a}, 32'd1);
        send_byte(8'h12, a);
        send_byte(8'h34, a);
        bus_stop();
        exp_div = 15'h1234;
        check_all("R9 pair reset on start");

        // R9: repeated START to a foreign address mutes the rest
        bus_start();
        send_byte({5'b11000, asel, 1'b0}, a);
        bus_start();
        send_byte(8'hC6, a);
        chk("R9 foreign after restart", {31'd0, a}, 32'd0);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        bus_stop();
        check_all("R9 R2 muted after restart");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule